// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block sits next to a simple in-order core and owns the control state around traps. At each instruction boundary it gets the committing instruction's PC and flags. It also gets that instruction's synchronous exception flags, its system-call and return-from-trap requests, an external interrupt request, and writes to its handler-base and interrupt-enable registers. Most boundaries carry no event. At the others, the block picks one event and acts on it.

When a trap is taken, the block saves three things: a resume PC, the processor flags and a cause code. It moves to kernel mode, keeps the previous mode and the previous enable bit, and clears the global interrupt enable. It then sends the core a one-cycle redirect to the handler, together with a flush of the instruction in flight. The handler address is either a single entry point or a per-cause slot. The low bits of the programmable base register choose between the two.

A return-from-trap does the reverse. It redirects to the saved PC, pulses a load of the saved flags, and puts back the saved mode and enable bit. The block leaves reset in kernel mode, with interrupts disabled and a base of zero. The saved mode is user and the saved enable is set, so the first return enters user code with interrupts on.

Top module: `trap_unit`

## Requirements
- R1: After reset: priv_mode=1 (kernel), irq_en=0, trap_base=0, saved_pc=0, saved_flags=0, trap_cause=0, and redirect, flush and flags_load are all low.
- R2: A synchronous cause is reported only by the first event in this order, with its code: fetch fault exc_flags[0] code 1, illegal instruction exc_flags[1] code 2, privilege violation code 3, decode exc_flags[2] code 4, address computation exc_flags[3] code 5, data-side fault exc_flags[4] code 6, arithmetic exc_flags[5] code 7, breakpoint exc_flags[6] code 8. A system call (code 9) is taken only when none of these is flagged.
- R3: For codes 1 to 7 the saved PC is instr_pc. For breakpoint (8) and system call (9) it is instr_pc+4.
- R4: Taking any trap sets priv_mode=1, stores flags_in in saved_flags, saves the previous mode and irq_en, and clears irq_en. Only a return can set priv_mode to 0.
- R5: If trap_base[1:0]==1 (vectored), the handler is (trap_base with bits 1:0 cleared) + 4×code, where the code is the low four cause bits. Any other value of trap_base[1:0] gives direct mode, where every trap goes to trap_base with bits 1:0 cleared.
- R6: An interrupt is taken only on a boundary where instr_valid=1, irq_en=1 and no synchronous cause, system call or return is present. It records trap_cause=0x8000000B (MSB set, code 11) and saves instr_pc.
- R7: In user mode, a return, a base write, an enable write or priv_instr raises code 3. The trap_base and irq_en writes are then dropped.
- R8: A return in kernel mode redirects to saved_pc, pulses flags_load for one cycle with saved_flags valid, and restores the saved mode and enable bit.
- R9: redirect and flush are high together for exactly the cycle after the boundary that takes a trap or a return. A redirect needs instr_valid on that boundary.
- R10: In kernel mode, a base or enable write takes effect in the following cycle. It is dropped if the same boundary takes a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is at its commit boundary |
| instr_pc | input | XLEN | PC of that instruction |
| flags_in | input | FLAGW | Current processor flags |
| exc_flags | input | 7 | Synchronous exception flags, bit assignment as in R2 |
| priv_instr | input | 1 | Instruction is privileged |
| syscall_req | input | 1 | Instruction is a system call |
| ret_req | input | 1 | Instruction is a return-from-trap |
| irq_req | input | 1 | External interrupt request |
| base_we | input | 1 | Instruction writes the handler base |
| base_wdata | input | XLEN | New handler base value |
| ie_we | input | 1 | Instruction writes the interrupt enable |
| ie_wdata | input | 1 | New interrupt enable value |
| redirect | output | 1 | One-cycle redirect pulse |
| flush | output | 1 | One-cycle squash of the in-flight instruction |
| redirect_pc | output | XLEN | Redirect target |
| priv_mode | output | 1 | 1 kernel, 0 user |
| irq_en | output | 1 | Global interrupt enable |
| trap_base | output | XLEN | Handler base register, mode in bits 1:0 |
| saved_pc | output | XLEN | Resume PC |
| saved_flags | output | FLAGW | Saved processor flags |
| flags_load | output | 1 | Pulse: core reloads flags from saved_flags |
| trap_cause | output | XLEN | Cause register |

## Verification
Every result is registered. A boundary presented before a clock edge shows up on the outputs in the cycle after that edge. This holds for the redirect and flush pulse, the flags_load pulse, the new mode, the saved PC, flags and cause, and for register writes. None of these has any further latency.

The bench drives inputs on the falling edge. A behavioural model advances on the rising edge, and every output is compared with it on the next falling edge. Each comparison therefore falls in exactly the cycle where the result is due. Directed checks sample that same falling edge for the priority, resume-PC, vectoring, masking and privilege-violation cases.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CODEW      = 4;
  localparam int NSYNC      = 8;
  localparam logic [CODEW-1:0] CODE_PRIV    = 4'd3;
  localparam logic [CODEW-1:0] CODE_BKPT    = 4'd8;
  localparam logic [CODEW-1:0] CODE_SYSCALL = 4'd9;
  localparam logic [CODEW-1:0] CODE_IRQ     = 4'd11;
  localparam logic [1:0]       MODE_VEC     = 2'd1;
endpackage

// File: rtl/trap_prio.sv
module trap_prio #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest set index wins
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int XLEN   = 32,
  parameter int CODEW  = 4,
  parameter bit VEC_EN = 1'b1
) (
  input  logic [XLEN-1:0]  base,
  input  logic [CODEW-1:0] code,
  output logic [XLEN-1:0]  target
);
  logic [XLEN-1:0] base_al;
  assign base_al = {base[XLEN-1:2], 2'b00};

  generate
    if (VEC_EN) begin : g_vec
      logic [XLEN-1:0] offs;
      assign offs   = {{(XLEN-CODEW-2){1'b0}}, code, 2'b00};
      assign target = (base[1:0] == trap_pkg::MODE_VEC) ? base_al + offs : base_al;
    end else begin : g_direct
      assign target = base_al;
    end
  endgenerate
endmodule

// File: rtl/trap_unit.sv
module trap_unit #(
  parameter int XLEN  = 32,
  parameter int FLAGW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [XLEN-1:0]  instr_pc,
  input  logic [FLAGW-1:0] flags_in,
  input  logic [6:0]       exc_flags,
  input  logic             priv_instr,
  input  logic             syscall_req,
  input  logic             ret_req,
  input  logic             irq_req,
  input  logic             base_we,
  input  logic [XLEN-1:0]  base_wdata,
  input  logic             ie_we,
  input  logic             ie_wdata,
  output logic             redirect,
  output logic             flush,
  output logic [XLEN-1:0]  redirect_pc,
  output logic             priv_mode,
  output logic             irq_en,
  output logic [XLEN-1:0]  trap_base,
  output logic [XLEN-1:0]  saved_pc,
  output logic [FLAGW-1:0] saved_flags,
  output logic             flags_load,
  output logic [XLEN-1:0]  trap_cause
);
  import trap_pkg::*;
  localparam int IW = $clog2(NSYNC);

  logic            prev_priv, prev_ie;
  logic            priv_viol, sync_any;
  logic [IW-1:0]   sync_idx;
  logic [NSYNC-1:0] sync_vec;
  logic            take_sync, take_sys, do_ret, take_irq, do_csr, take;
  logic [CODEW-1:0] code;
  logic [XLEN-1:0] resume_pc, handler_pc;

  // user-mode use of a privileged operation
  assign priv_viol = ~priv_mode & (priv_instr | ret_req | base_we | ie_we);
  assign sync_vec  = {exc_flags[6:2], priv_viol, exc_flags[1:0]};

  trap_prio #(.N(NSYNC)) u_prio (
    .req (sync_vec),
    .any (sync_any),
    .idx (sync_idx)
  );

  assign take_sync = instr_valid & sync_any;
  assign take_sys  = instr_valid & ~sync_any & syscall_req;
  assign do_ret    = instr_valid & ~sync_any & ~syscall_req & ret_req;
  assign take_irq  = instr_valid & ~sync_any & ~syscall_req & ~ret_req & irq_req & irq_en;
  assign do_csr    = instr_valid & ~sync_any & ~syscall_req & ~ret_req & ~take_irq;
  assign take      = take_sync | take_sys | take_irq;

  always_comb begin
    if (take_sync)     code = CODEW'(sync_idx) + CODEW'(1);
    else if (take_sys) code = CODE_SYSCALL;
    else               code = CODE_IRQ;
  end

  // trap-class causes resume after the instruction
  assign resume_pc = (!take_irq && code >= CODE_BKPT) ? instr_pc + XLEN'(4) : instr_pc;

  trap_vector #(.XLEN(XLEN), .CODEW(CODEW), .VEC_EN(1'b1)) u_vec (
    .base   (trap_base),
    .code   (code),
    .target (handler_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect    <= 1'b0;
      flush       <= 1'b0;
      flags_load  <= 1'b0;
      redirect_pc <= '0;
      priv_mode   <= 1'b1;
      irq_en      <= 1'b0;
      prev_priv   <= 1'b0;
      prev_ie     <= 1'b1;
      trap_base   <= '0;
      saved_pc    <= '0;
      saved_flags <= '0;
      trap_cause  <= '0;
    end else begin
      redirect   <= take | do_ret;
      flush      <= take | do_ret;
      flags_load <= do_ret;
      if (take) begin
        redirect_pc <= handler_pc;
        saved_pc    <= resume_pc;
        saved_flags <= flags_in;
        trap_cause  <= {take_irq, {(XLEN-1-CODEW){1'b0}}, code};
        prev_priv   <= priv_mode;
        prev_ie     <= irq_en;
        priv_mode   <= 1'b1;
        irq_en      <= 1'b0;
      end else if (do_ret) begin
        redirect_pc <= saved_pc;
        priv_mode   <= prev_priv;
        irq_en      <= prev_ie;
      end else if (do_csr) begin
        if (base_we) trap_base <= base_wdata;
        if (ie_we)   irq_en    <= ie_wdata;
      end
    end
  end
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            instr_valid,
  input logic [XLEN-1:0] instr_pc,
  input logic            ret_req,
  input logic            redirect,
  input logic            flush,
  input logic            flags_load,
  input logic [XLEN-1:0] redirect_pc,
  input logic            priv_mode,
  input logic            irq_en,
  input logic [XLEN-1:0] saved_pc,
  input logic [XLEN-1:0] trap_cause
);
  logic trap_seen;
  assign trap_seen = redirect && !flags_load;

  p_fault_pc_r3: assert property (@(posedge clk) disable iff (rst)
    (trap_seen && !trap_cause[XLEN-1] && trap_cause < 8) |-> saved_pc == $past(instr_pc));

  p_trap_pc_r3: assert property (@(posedge clk) disable iff (rst)
    (trap_seen && !trap_cause[XLEN-1] && trap_cause >= 8) |-> saved_pc == $past(instr_pc) + 4);

  p_enter_kernel_r4: assert property (@(posedge clk) disable iff (rst)
    trap_seen |-> (priv_mode && !irq_en));

  p_exit_by_ret_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(priv_mode) |-> $past(ret_req && instr_valid));

  p_align_r5: assert property (@(posedge clk) disable iff (rst)
    trap_seen |-> redirect_pc[1:0] == 2'b00);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (trap_seen && trap_cause[XLEN-1]) |-> $past(irq_en));

  p_redirect_src_r9: assert property (@(posedge clk) disable iff (rst)
    redirect |-> $past(instr_valid));

  p_flush_pair_r9: assert property (@(posedge clk) disable iff (rst)
    flush == redirect);
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_pc(instr_pc),
  .ret_req(ret_req), .redirect(redirect), .flush(flush), .flags_load(flags_load),
  .redirect_pc(redirect_pc), .priv_mode(priv_mode), .irq_en(irq_en),
  .saved_pc(saved_pc), .trap_cause(trap_cause)
);

// File: tb/tb_trap_unit.sv
`timescale 1ns/1ps
module tb_trap_unit;
  localparam int XLEN = 32;
  localparam int FLAGW = 4;

  logic clk = 0, rst = 1;
  logic instr_valid = 0;
  logic [XLEN-1:0] instr_pc = 0;
  logic [FLAGW-1:0] flags_in = 0;
  logic [6:0] exc_flags = 0;
  logic priv_instr = 0, syscall_req = 0, ret_req = 0, irq_req = 0;
  logic base_we = 0, ie_we = 0, ie_wdata = 0;
  logic [XLEN-1:0] base_wdata = 0;
  logic redirect, flush, flags_load, priv_mode, irq_en;
  logic [XLEN-1:0] redirect_pc, trap_base, saved_pc, trap_cause;
  logic [FLAGW-1:0] saved_flags;

  int checks = 0, failures = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  trap_unit #(.XLEN(XLEN), .FLAGW(FLAGW)) dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_pc(instr_pc),
    .flags_in(flags_in), .exc_flags(exc_flags), .priv_instr(priv_instr),
    .syscall_req(syscall_req), .ret_req(ret_req), .irq_req(irq_req),
    .base_we(base_we), .base_wdata(base_wdata), .ie_we(ie_we), .ie_wdata(ie_wdata),
    .redirect(redirect), .flush(flush), .redirect_pc(redirect_pc),
    .priv_mode(priv_mode), .irq_en(irq_en), .trap_base(trap_base),
    .saved_pc(saved_pc), .saved_flags(saved_flags), .flags_load(flags_load),
    .trap_cause(trap_cause)
  );

  // behavioural reference state
  bit m_priv, m_ie, m_spriv, m_spie, m_redir, m_fload;
  logic [31:0] m_base, m_epc, m_cause, m_rpc;
  logic [FLAGW-1:0] m_flags;

  task automatic m_trap(input int code, input logic [31:0] epc, input bit is_irq);
    logic [31:0] b;
    b = m_base & 32'hFFFF_FFFC;
    m_rpc   = (m_base[1:0] == 2'd1) ? b + 32'(code * 4) : b;
    m_epc   = epc;
    m_flags = flags_in;
    m_cause = is_irq ? (32'h8000_0000 | 32'(code)) : 32'(code);
    m_spriv = m_priv;
    m_spie  = m_ie;
    m_ie    = 0;
    m_priv  = 1;
    m_redir = 1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_priv = 1; m_ie = 0; m_spriv = 0; m_spie = 1; m_redir = 0; m_fload = 0;
      m_base = 0; m_epc = 0; m_cause = 0; m_rpc = 0; m_flags = 0;
    end else begin
      int code;
      bit viol;
      m_redir = 0; m_fload = 0;
      if (instr_valid) begin
        viol = !m_priv && (priv_instr || ret_req || base_we || ie_we);
        if (exc_flags[0]) code = 1;
        else if (exc_flags[1]) code = 2;
        else if (viol) code = 3;
        else if (exc_flags[2]) code = 4;
        else if (exc_flags[3]) code = 5;
        else if (exc_flags[4]) code = 6;
        else if (exc_flags[5]) code = 7;
        else if (exc_flags[6]) code = 8;
        else if (syscall_req) code = 9;
        else code = 0;
        if (code != 0) m_trap(code, (code >= 8) ? instr_pc + 4 : instr_pc, 0);
        else if (ret_req) begin
          m_redir = 1; m_fload = 1; m_rpc = m_epc; m_priv = m_spriv; m_ie = m_spie;
        end else if (irq_req && m_ie) m_trap(11, instr_pc, 1);
        else begin
          if (base_we) m_base = base_wdata;
          if (ie_we) m_ie = ie_wdata;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare against model on every falling edge
  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R4", "priv_mode", 32'(priv_mode), 32'(m_priv));
      chk("R6", "irq_en", 32'(irq_en), 32'(m_ie));
      chk("R10", "trap_base", trap_base, m_base);
      chk("R3", "saved_pc", saved_pc, m_epc);
      chk("R8", "saved_flags", 32'(saved_flags), 32'(m_flags));
      chk("R2", "trap_cause", trap_cause, m_cause);
      chk("R9", "redirect", 32'(redirect), 32'(m_redir));
      chk("R9", "flush", 32'(flush), 32'(m_redir));
      chk("R8", "flags_load", 32'(flags_load), 32'(m_fload));
      if (m_redir) chk("R5", "redirect_pc", redirect_pc, m_rpc);
    end
  end

  task automatic clear_in();
    instr_valid = 0; exc_flags = 0; priv_instr = 0; syscall_req = 0; ret_req = 0;
    irq_req = 0; base_we = 0; ie_we = 0;
  endtask

  task automatic issue(input logic [31:0] pc, input logic [6:0] ex, input bit pv,
                       input bit sc, input bit rt, input bit irq,
                       input bit bwe, input logic [31:0] bw, input bit iwe, input bit iw);
    @(negedge clk);
    clear_in();
    instr_valid = 1; instr_pc = pc; exc_flags = ex; priv_instr = pv; syscall_req = sc;
    ret_req = rt; irq_req = irq; base_we = bwe; base_wdata = bw; ie_we = iwe; ie_wdata = iw;
    flags_in = flags_in + 4'd3;
  endtask

  task automatic settle();
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_ret();
    issue(32'h0, 7'h0, 0, 0, 1, 0, 0, 0, 0, 0);
    settle();
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    started = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset priv", 32'(priv_mode), 1);
    chk("R1", "reset ie", 32'(irq_en), 0);
    chk("R1", "reset base", trap_base, 0);
    chk("R1", "reset cause", trap_cause, 0);
    chk("R1", "reset redirect", 32'(redirect), 0);

    // R10 kernel writes
    issue(32'h10, 0, 0, 0, 0, 0, 1, 32'h1000, 0, 0);
    issue(32'h14, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    settle();
    chk("R10", "base written", trap_base, 32'h1000);
    chk("R10", "ie written", 32'(irq_en), 1);
    // R8 first return drops to user, enable from saved bit
    do_ret();
    chk("R8", "ret mode", 32'(priv_mode), 0);

    // R2 all flags: fetch wins
    issue(32'h200, 7'h7F, 0, 1, 0, 1, 0, 0, 0, 0);
    settle();
    chk("R2", "all flags cause", trap_cause, 1);
    chk("R5", "direct target", redirect_pc, 32'h1000);
    do_ret();
    issue(32'h240, 7'h70, 0, 0, 0, 0, 0, 0, 0, 0);
    settle();
    chk("R2", "data over arith", trap_cause, 6);
    chk("R3", "fault pc", saved_pc, 32'h240);
    do_ret();
    // R3 breakpoint resumes after
    issue(32'h300, 7'h40, 0, 0, 0, 0, 0, 0, 0, 0);
    settle();
    chk("R3", "bkpt pc", saved_pc, 32'h304);
    do_ret();
    // syscall, then vectored base from kernel
    issue(32'h400, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    settle();
    chk("R3", "syscall pc", saved_pc, 32'h404);
    chk("R4", "syscall kernel", 32'(priv_mode), 1);
    issue(32'h404, 0, 0, 0, 0, 0, 1, 32'h2001, 0, 0);
    settle();
    do_ret();
    // R7 user base write
    issue(32'h500, 0, 0, 0, 0, 0, 1, 32'h7770, 0, 0);
    settle();
    chk("R7", "viol cause", trap_cause, 3);
    chk("R7", "base kept", trap_base, 32'h2001);
    chk("R5", "vectored target", redirect_pc, 32'h200C);
    do_ret();
    // R6 interrupt
    issue(32'h600, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    settle();
    chk("R6", "irq cause", trap_cause, 32'h8000_000B);
    chk("R6", "irq pc", saved_pc, 32'h600);
    chk("R5", "irq vector", redirect_pc, 32'h202C);
    do_ret();
    // R6 no boundary
    @(negedge clk); irq_req = 1;
    settle();
    chk("R6", "irq without boundary", 32'(redirect), 0);
    // R6 syscall outranks irq
    issue(32'h700, 0, 0, 1, 0, 1, 0, 0, 0, 0);
    settle();
    chk("R6", "syscall over irq", trap_cause, 9);
    // R6 masked in kernel
    issue(32'h800, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    settle();
    chk("R6", "masked irq", 32'(redirect), 0);
    // R10 write dropped when trapping
    issue(32'h804, 7'h04, 0, 0, 0, 0, 0, 0, 1, 1);
    settle();
    chk("R10", "ie write dropped", 32'(irq_en), 0);
    chk("R2", "decode cause", trap_cause, 4);
    do_ret();

    // mixed stimulus against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      clear_in();
      instr_valid = ($urandom % 4) != 0;
      instr_pc    = $urandom & 32'hFFFF_FFFC;
      flags_in    = 4'($urandom);
      exc_flags   = (($urandom % 6) == 0) ? 7'(1 << ($urandom % 7)) | 7'(($urandom % 3 == 0) ? $urandom : 0) : 7'h0;
      priv_instr  = ($urandom % 10) == 0;
      syscall_req = ($urandom % 8) == 0;
      ret_req     = ($urandom % 4) == 0;
      irq_req     = ($urandom % 3) == 0;
      base_we     = ($urandom % 10) == 0;
      base_wdata  = $urandom;
      ie_we       = ($urandom % 6) == 0;
      ie_wdata    = 1'($urandom);
    end
    settle();
    settle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule